// File: doc/BRIEF.md
# Flash Device Operating-Mode Controller

This block is the mode state machine of a flash memory device that sits on an asynchronous host bus. It samples chip-enable, write-enable, output-enable, the address and the write data on its own clock. It keeps the device in one of three modes: Reset, Normal or Deep Power-Down. It decides which host writes take effect, whether a read returns register data, returns zeros or leaves the data bus undriven, and when the internal voltage regulators may run.

Software changes mode with a two-step handshake. It first writes a mode request to a command register, then writes the bitwise complement of that value to a check register. Deep Power-Down is left without any write, through a wake sequence made only of reads. An active-low hardware reset input can also force the device down, and releasing it lands the device in Reset mode with a short busy window.

The host bus is not a stream. It has no valid/ready pair and no back-pressure: the block can never stall a cycle, so every qualified cycle is acted on the first clock it is seen. A small bank of scratch registers stands in for the device's ordinary registers, so the bench can see which writes took effect.

Top module: `pmc_mode_ctrl`

## Requirements
- R1: A write cycle exists only while `ce_n` and `we_n` are both low, and a read cycle only while `ce_n` and `oe_n` are both low. Each cycle acts once, on the first clock it is seen. A strobe given with `ce_n` high has no effect, and `data_oe` stays low for it.
- R2: In Reset mode (`mode` = 00), writes to the scratch registers (addresses 0x1004 and 0x1005) are ignored. Writes to the command register (0x1002) and the check register (0x1003) are accepted.
- R3: In Reset mode every read drives the bus (`data_oe` = 1) with `rdata` = 0x00. After reset the block is in Reset mode with `reg_en` = 1 and `busy` = 0.
- R4: A command write followed, with no other cycle in between, by a check write equal to its bitwise complement applies the mode coded in command bits [1:0]: 00 Reset, 01 Normal, 10 Deep Power-Down. In Normal mode, reads of 0x1002, 0x1003 and the scratch addresses return the stored values, and other addresses read 0x00.
- R5: The handshake is cancelled by a check value that is not the complement, or by any other read or write between the two writes. Mode is then unchanged.
- R6: A confirmed code 10 does not change mode while `ce_n` stays low. Deep Power-Down (`mode` = 10) starts on the first clock with `ce_n` high, and `reg_en` falls to 0 at that moment.
- R7: Holding `hard_rst_n` low in Normal mode forces Deep Power-Down, and wake reads have no effect while it stays low. On release the block enters Reset mode, and `busy` is high for exactly 8 clocks.
- R8: In Deep Power-Down, writes (including handshake writes) have no effect, and `data_oe` stays low on every read.
- R9: Four consecutive reads of 0x1FFF leave Deep Power-Down and return to the mode held before. An access to any other address restarts the count.
- R10: A single read inside the boot window 0x0000 to 0x07FF leaves Deep Power-Down and returns to the previous mode. This works for both Reset and Normal as the previous mode.
- R11: Entering and leaving Deep Power-Down leaves the command, check and scratch register values unchanged.
- R12: A confirmed code 11 leaves the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Power-on reset, active low |
| hard_rst_n | input | 1 | Host hardware reset pin, active low |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 13 | Host address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read data |
| data_oe | output | 1 | Data bus drive enable |
| reg_en | output | 1 | Regulator enable |
| busy | output | 1 | Busy after hardware reset release |
| mode | output | 2 | Current mode: 00 Reset, 01 Normal, 10 Deep Power-Down |

## Verification
The bench uses the default parameters: a 13-bit address, 8-bit data, two scratch registers, a wake count of four, a busy window of eight clocks and a 2K boot window. With a count of four, the bench can make three wake reads, break them with a stray access, and then finish a full run. With eight busy clocks, it can count every high sample of `busy` after release. With two scratch registers, a fixed-seed random mix of writes, reads, stray strobes and unmapped reads can land on every register many times and be compared against a bench model.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    MODE_RST = 2'b00,
    MODE_NRM = 2'b01,
    MODE_DPD = 2'b10
  } pmc_mode_e;
endpackage

// File: rtl/pmc_bus_decode.sv
module pmc_bus_decode #(
  parameter int unsigned AW          = 13,
  parameter int unsigned NUM_SCRATCH = 2,
  parameter int unsigned CTRL_ADDR   = 'h1002,
  parameter int unsigned CONF_ADDR   = 'h1003,
  parameter int unsigned SCR_BASE    = 'h1004,
  parameter int unsigned WAKE_ADDR   = 'h1FFF,
  parameter int unsigned BOOT_BITS   = 11,
  parameter int unsigned BOOT_TAG    = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ce_n,
  input  logic                   we_n,
  input  logic                   oe_n,
  input  logic [AW-1:0]          addr,
  output logic                   wr_start,
  output logic                   rd_start,
  output logic                   rd_act,
  output logic                   hit_ctrl,
  output logic                   hit_conf,
  output logic                   hit_wake,
  output logic                   hit_boot,
  output logic [NUM_SCRATCH-1:0] hit_scr
);
  localparam int unsigned TW = AW - BOOT_BITS;

  logic wr_act, wr_prev_q, rd_prev_q;

  assign wr_act   = !ce_n && !we_n;
  assign rd_act   = !ce_n && !oe_n && we_n;
  assign wr_start = wr_act && !wr_prev_q;
  assign rd_start = rd_act && !rd_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_prev_q <= 1'b0;
      rd_prev_q <= 1'b0;
    end else begin
      wr_prev_q <= wr_act;
      rd_prev_q <= rd_act;
    end
  end

  assign hit_ctrl = (addr == AW'(CTRL_ADDR));
  assign hit_conf = (addr == AW'(CONF_ADDR));
  assign hit_wake = (addr == AW'(WAKE_ADDR));
  assign hit_boot = (addr[AW-1:BOOT_BITS] == TW'(BOOT_TAG));

  for (genvar g = 0; g < NUM_SCRATCH; g++) begin : g_scr_hit
    assign hit_scr[g] = (addr == AW'(SCR_BASE + g));
  end

  // R1: one action per bus cycle
  a_r1_write_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> !wr_start);
  a_r1_read_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start |=> !rd_start);
endmodule

// File: rtl/pmc_cmd_seq.sv
module pmc_cmd_seq #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev,
  input  logic          wr_ctrl,
  input  logic          wr_conf,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] ctrl_q,
  output logic [DW-1:0] conf_q,
  output logic          cmd_fire,
  output logic [1:0]    cmd_code
);
  logic armed_q;

  assign cmd_fire = ev && wr_conf && armed_q && (wdata == ~ctrl_q);
  assign cmd_code = ctrl_q[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      conf_q  <= '0;
      armed_q <= 1'b0;
    end else if (ev) begin
      if (wr_ctrl) begin
        ctrl_q  <= wdata;
        armed_q <= 1'b1;
      end else begin
        armed_q <= 1'b0;
        if (wr_conf) conf_q <= wdata;
      end
    end
  end

  // R5: any cycle other than a command write disarms the handshake
  a_r5_arm_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && !wr_ctrl) |=> !armed_q);
endmodule

// File: rtl/pmc_wake.sv
module pmc_wake #(
  parameter int unsigned WAKE_READS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic rd_start,
  input  logic access,
  input  logic hit_wake,
  input  logic hit_boot,
  output logic wake
);
  localparam int unsigned CW = (WAKE_READS > 1) ? $clog2(WAKE_READS) : 1;

  logic [CW-1:0] cnt_q;
  logic          last;

  assign last = (32'(cnt_q) == WAKE_READS - 1);
  assign wake = en && rd_start && (hit_boot || (hit_wake && last));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!en) begin
      cnt_q <= '0;
    end else if (access) begin
      if (rd_start && hit_wake && !last) cnt_q <= cnt_q + CW'(1);
      else                               cnt_q <= '0;
    end
  end

  // R9: counter never passes the wake threshold and restarts on other accesses
  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt_q) < WAKE_READS);
  a_r9_clear_other: assert property (@(posedge clk) disable iff (!rst_n)
    (en && access && !(rd_start && hit_wake)) |=> (cnt_q == '0));
endmodule

// File: rtl/pmc_busy.sv
module pmc_busy #(
  parameter int unsigned BUSY_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  localparam int unsigned BW = $clog2(BUSY_CYCLES + 1);

  logic [BW-1:0] cnt_q;

  assign busy = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= BW'(BUSY_CYCLES);
    else if (cnt_q != '0)    cnt_q <= cnt_q - BW'(1);
  end

  // R7: busy window counts down one per clock
  a_r7_busy_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !load) |=> (cnt_q == $past(cnt_q) - BW'(1)));
endmodule

// File: rtl/pmc_mode_ctrl.sv
module pmc_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int unsigned AW          = 13,
  parameter int unsigned DW          = 8,
  parameter int unsigned NUM_SCRATCH = 2,
  parameter int unsigned CTRL_ADDR   = 'h1002,
  parameter int unsigned CONF_ADDR   = 'h1003,
  parameter int unsigned SCR_BASE    = 'h1004,
  parameter int unsigned WAKE_ADDR   = 'h1FFF,
  parameter int unsigned WAKE_READS  = 4,
  parameter int unsigned BOOT_BITS   = 11,
  parameter int unsigned BOOT_TAG    = 0,
  parameter int unsigned BUSY_CYCLES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hard_rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          data_oe,
  output logic          reg_en,
  output logic          busy,
  output logic [1:0]    mode
);
  pmc_mode_e mode_q, prev_q;
  logic      forced_q, pend_q, reg_en_q, hrst_q;

  logic wr_start, rd_start, rd_act;
  logic hit_ctrl, hit_conf, hit_wake, hit_boot;
  logic [NUM_SCRATCH-1:0] hit_scr;

  logic [DW-1:0] ctrl_q, conf_q;
  logic          cmd_fire;
  logic [1:0]    cmd_code;
  logic          ev, wake, wake_en, hrel;

  logic [NUM_SCRATCH-1:0][DW-1:0] scr_q;

  pmc_bus_decode #(
    .AW(AW), .NUM_SCRATCH(NUM_SCRATCH), .CTRL_ADDR(CTRL_ADDR),
    .CONF_ADDR(CONF_ADDR), .SCR_BASE(SCR_BASE), .WAKE_ADDR(WAKE_ADDR),
    .BOOT_BITS(BOOT_BITS), .BOOT_TAG(BOOT_TAG)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .wr_start(wr_start), .rd_start(rd_start), .rd_act(rd_act),
    .hit_ctrl(hit_ctrl), .hit_conf(hit_conf), .hit_wake(hit_wake),
    .hit_boot(hit_boot), .hit_scr(hit_scr)
  );

  // Handshake and register writes only count outside power-down
  assign ev = (wr_start || rd_start) && (mode_q != MODE_DPD);

  pmc_cmd_seq #(.DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .ev(ev),
    .wr_ctrl(wr_start && hit_ctrl), .wr_conf(wr_start && hit_conf),
    .wdata(wdata), .ctrl_q(ctrl_q), .conf_q(conf_q),
    .cmd_fire(cmd_fire), .cmd_code(cmd_code)
  );

  assign wake_en = (mode_q == MODE_DPD) && !forced_q;

  pmc_wake #(.WAKE_READS(WAKE_READS)) u_wake (
    .clk(clk), .rst_n(rst_n), .en(wake_en), .rd_start(rd_start),
    .access(wr_start || rd_start), .hit_wake(hit_wake),
    .hit_boot(hit_boot), .wake(wake)
  );

  assign hrel = !hrst_q && hard_rst_n;

  pmc_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_n), .load(hrel), .busy(busy)
  );

  // Mode state machine, highest priority first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_RST;
      prev_q   <= MODE_RST;
      forced_q <= 1'b0;
      pend_q   <= 1'b0;
      reg_en_q <= 1'b1;
      hrst_q   <= 1'b1;
    end else begin
      hrst_q <= hard_rst_n;
      if (hrel) begin
        mode_q   <= MODE_RST;
        forced_q <= 1'b0;
        pend_q   <= 1'b0;
        reg_en_q <= 1'b1;
      end else if (!hard_rst_n && mode_q == MODE_NRM) begin
        mode_q   <= MODE_DPD;
        prev_q   <= MODE_NRM;
        forced_q <= 1'b1;
        pend_q   <= 1'b0;
        reg_en_q <= 1'b0;
      end else if (wake) begin
        mode_q   <= prev_q;
        reg_en_q <= 1'b1;
      end else if (cmd_fire) begin
        case (cmd_code)
          2'b00: begin mode_q <= MODE_RST; pend_q <= 1'b0; end
          2'b01: begin mode_q <= MODE_NRM; pend_q <= 1'b0; end
          2'b10: pend_q <= 1'b1;
          default: ;
        endcase
      end else if (pend_q && ce_n) begin
        mode_q   <= MODE_DPD;
        prev_q   <= mode_q;
        pend_q   <= 1'b0;
        reg_en_q <= 1'b0;
      end
    end
  end

  // Ordinary registers: writable in Normal mode only
  for (genvar g = 0; g < NUM_SCRATCH; g++) begin : g_scr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                        scr_q[g] <= '0;
      else if (wr_start && hit_scr[g] && mode_q == MODE_NRM) scr_q[g] <= wdata;
    end
  end

  // Read path
  always_comb begin
    rdata = '0;
    if (mode_q == MODE_NRM) begin
      if (hit_ctrl) rdata = ctrl_q;
      if (hit_conf) rdata = conf_q;
      for (int i = 0; i < NUM_SCRATCH; i++)
        if (hit_scr[i]) rdata = scr_q[i];
    end
  end

  assign data_oe = rd_act && (mode_q != MODE_DPD);
  assign reg_en  = reg_en_q;
  assign mode    = mode_q;

  // R6: regulator enable follows the power-down state
  a_r6_reg_tracks_mode: assert property (@(posedge clk) disable iff (!rst_n)
    reg_en_q == (mode_q != MODE_DPD));
  // R8 / R11: nothing stored changes during power-down
  a_r8_dpd_regs_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_DPD) |=> ($stable(scr_q) && $stable(ctrl_q) && $stable(conf_q)));
  // R7: reset pin release lands in Reset with busy raised
  a_r7_release_to_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hard_rst_n) |=> (mode_q == MODE_RST && busy));
endmodule

// File: tb/tb_pmc_mode_ctrl.sv
`timescale 1ns/1ps
module tb_pmc_mode_ctrl;
  localparam logic [12:0] A_CTRL = 13'h1002;
  localparam logic [12:0] A_CONF = 13'h1003;
  localparam logic [12:0] A_SCR0 = 13'h1004;
  localparam logic [12:0] A_WAKE = 13'h1FFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0, hard_rst_n = 1'b1;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [12:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        data_oe, reg_en, busy;
  logic [1:0]  mode;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [1:0] m_mode;
  logic [7:0] m_ctrl, m_conf;
  logic [7:0] m_scr [2];

  always #10 clk = ~clk;

  pmc_mode_ctrl dut (
    .clk(clk), .rst_n(rst_n), .hard_rst_n(hard_rst_n), .ce_n(ce_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .wdata(wdata), .rdata(rdata),
    .data_oe(data_oe), .reg_en(reg_en), .busy(busy), .mode(mode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [12:0] a);
    if (m_mode != 2'b01) return 8'h00;
    if (a == A_CTRL) return m_ctrl;
    if (a == A_CONF) return m_conf;
    if (a == A_SCR0) return m_scr[0];
    if (a == A_SCR0 + 13'd1) return m_scr[1];
    return 8'h00;
  endfunction

  task automatic bus_write(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; ce_n = 1'b0; we_n = 1'b0;
    repeat (2) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_read(input logic [12:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); d = rdata; oe = data_oe;
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic handshake(input logic [7:0] code);
    bus_write(A_CTRL, code);
    bus_write(A_CONF, ~code);
    if (m_mode != 2'b10) begin m_ctrl = code; m_conf = ~code; end
  endtask

  initial begin
    #4000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic       oe;
    void'($urandom(32'd7));
    m_mode = 2'b00; m_ctrl = 0; m_conf = 0; m_scr[0] = 0; m_scr[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: reset state
    chk("R3 mode", 32'(mode), 0);
    chk("R3 reg_en", 32'(reg_en), 1);
    chk("R3 busy", 32'(busy), 0);
    chk("R3 idle oe", 32'(data_oe), 0);
    bus_read(A_CTRL, d, oe);
    chk("R3 read data", 32'(d), 0);
    chk("R3 read drives", 32'(oe), 1);

    // R2: scratch write ignored in Reset
    bus_write(A_SCR0, 8'h5A);

    // R4: enter Normal
    handshake(8'h01); m_mode = 2'b01;
    chk("R4 normal", 32'(mode), 1);
    bus_read(A_CTRL, d, oe); chk("R4 ctrl rd", 32'(d), 32'h01);
    bus_read(A_CONF, d, oe); chk("R4 conf rd", 32'(d), 32'hFE);
    bus_read(A_SCR0, d, oe); chk("R2 scr ignored", 32'(d), 0);
    // R2: ctrl/conf were accepted in Reset
    m_mode = 2'b00;
    bus_write(A_CTRL, 8'h00); // prepare: confirm back to reset
    bus_write(A_CONF, 8'hFF); m_ctrl = 8'h00; m_conf = 8'hFF;
    chk("R4 to reset", 32'(mode), 0);
    handshake(8'h01); m_mode = 2'b01;
    bus_read(A_CTRL, d, oe); chk("R2 ctrl accepted", 32'(d), 32'h01);

    // R1 and R4: random traffic in Normal
    for (int it = 0; it < 80; it++) begin
      int op = int'($urandom % 4);
      int idx = int'($urandom % 2);
      logic [7:0] rv = 8'($urandom);
      case (op)
        0: begin bus_write(A_SCR0 + 13'(idx), rv); m_scr[idx] = rv; end
        1: begin
          logic [12:0] a = 13'h1002 + 13'($urandom % 4);
          bus_read(a, d, oe);
          chk("R4 random read", 32'(d), 32'(exp_read(a)));
        end
        2: begin
          @(negedge clk); addr = A_SCR0 + 13'(idx); wdata = rv; we_n = 1'b0; oe_n = 1'b1;
          repeat (2) @(negedge clk);
          chk("R1 no oe without ce", 32'(data_oe), 0);
          we_n = 1'b1; oe_n = 1'b0;
          @(negedge clk);
          chk("R1 oe needs ce", 32'(data_oe), 0);
          oe_n = 1'b1;
          bus_read(A_SCR0 + 13'(idx), d, oe);
          chk("R1 stray strobe", 32'(d), 32'(m_scr[idx]));
        end
        default: begin
          logic [12:0] a = 13'h0800 + 13'($urandom % 1024);
          bus_read(a, d, oe);
          chk("R4 unmapped", {23'(0), oe, d}, 32'h100);
        end
      endcase
    end

    // R5: intervening cycle and wrong complement cancel
    bus_write(A_CTRL, 8'h00); m_ctrl = 8'h00;
    bus_read(A_SCR0, d, oe);
    bus_write(A_CONF, 8'hFF); m_conf = 8'hFF;
    chk("R5 intervening", 32'(mode), 1);
    bus_write(A_CTRL, 8'h00);
    bus_write(A_CONF, 8'h00); m_conf = 8'h00;
    chk("R5 bad complement", 32'(mode), 1);

    // R12: code 11 ignored
    handshake(8'h03);
    chk("R12 code 11", 32'(mode), 1);

    // R6: DPD waits for ce_n high
    bus_write(A_SCR0, 8'h3C); m_scr[0] = 8'h3C;
    bus_write(A_SCR0 + 13'd1, 8'hC3); m_scr[1] = 8'hC3;
    bus_write(A_CTRL, 8'h02);
    @(negedge clk); addr = A_CONF; wdata = 8'hFD; ce_n = 1'b0; we_n = 1'b0;
    repeat (2) @(negedge clk); we_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 held ce", 32'(mode), 1);
    ce_n = 1'b1;
    @(negedge clk);
    chk("R6 dpd", 32'(mode), 2);
    chk("R6 reg off", 32'(reg_en), 0);
    m_ctrl = 8'h02; m_conf = 8'hFD;

    // R8: writes ignored, bus undriven
    bus_write(A_SCR0, 8'hFF);
    handshake(8'h01);
    chk("R8 cmd ignored", 32'(mode), 2);
    bus_read(A_SCR0, d, oe);
    chk("R8 no drive", 32'(oe), 0);

    // R9: wake by four top reads, count restarted by other access
    repeat (3) bus_read(A_WAKE, d, oe);
    chk("R9 three reads", 32'(mode), 2);
    bus_read(A_SCR0, d, oe);
    repeat (3) bus_read(A_WAKE, d, oe);
    chk("R9 restart", 32'(mode), 2);
    bus_read(A_WAKE, d, oe);
    chk("R9 woke", 32'(mode), 1);
    chk("R9 reg on", 32'(reg_en), 1);

    // R11: registers preserved
    bus_read(A_SCR0, d, oe);         chk("R11 scr0", 32'(d), 32'h3C);
    bus_read(A_SCR0 + 13'd1, d, oe); chk("R11 scr1", 32'(d), 32'hC3);
    bus_read(A_CTRL, d, oe);         chk("R11 ctrl", 32'(d), 32'h02);
    bus_read(A_CONF, d, oe);         chk("R11 conf", 32'(d), 32'hFD);

    // R10: boot window wake back to Normal
    handshake(8'h02);
    chk("R10 in dpd", 32'(mode), 2);
    bus_read(13'h0123, d, oe);
    chk("R10 wake normal", 32'(mode), 1);
    // R10: boot window wake back to Reset
    handshake(8'h00); m_mode = 2'b00;
    handshake(8'h02);
    chk("R10 dpd from reset", 32'(mode), 2);
    bus_read(13'h07FF, d, oe);
    chk("R10 wake reset", 32'(mode), 0);

    // R7: forced power-down by reset pin
    handshake(8'h01); m_mode = 2'b01;
    @(negedge clk); hard_rst_n = 1'b0;
    @(negedge clk);
    chk("R7 forced dpd", 32'(mode), 2);
    chk("R7 reg off", 32'(reg_en), 0);
    repeat (4) bus_read(A_WAKE, d, oe);
    chk("R7 wake blocked", 32'(mode), 2);
    @(negedge clk); hard_rst_n = 1'b1;
    begin
      int nb = 0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (i == 0) chk("R7 reset mode", 32'(mode), 0);
        if (busy) nb++;
      end
      chk("R7 busy length", 32'(nb), 8);
    end
    finish_run();
  end
endmodule